// File: doc/BRIEF.md
# Floating-Point Instruction Legality Checker

This block sits beside the coprocessor issue path and screens every floating-point instruction word before it reaches the execution unit. For each word it receives, it applies a set of legality rules. The rules use the word itself, the processor's privilege level, the decoded precision, the transfer start register and count, and the current short-vector length and stride. One cycle later it reports whether the word must be bounced to support code as undefined, or whether its result is unpredictable. A 3-bit reason code comes with the verdict.

An undefined verdict is meant to trigger the bounce. An unpredictable verdict is informational: software may choose how to handle it. Full decoding and execution of legal operations are outside this block.

Top module: `fpl_legality_top`

## Requirements
- R1: `out_valid` goes high exactly one cycle after a cycle with `in_valid` high. After a cycle with `in_valid` low, `out_valid`, `undef` and `unpred` are 0 and `reason` is 0.
- R2: The word is undefined with reason 1 in any of these cases: the condition field `instr[31:28]` is 4'hF; the class field `instr[27:25]` is neither 3'b110 (load/store) nor 3'b111 (coprocessor op); the coprocessor number `instr[11:8]` is neither 4'hA nor 4'hB; or the word is an arithmetic op (class 3'b111 with `instr[4]`=0) whose opcode `{instr[24],instr[21:20],instr[6]}` is 13 to 15, or is 12 with sub-op `instr[3:0]` of 9 or more.
- R3: A load/store is undefined with reason 2 when its addressing bits are P=`instr[24]`, U=`instr[23]`, W=`instr[21]` with P=0,U=0 (either W), or with P=1,U=1,W=1.
- R4: A control move (class 3'b111 with `instr[4]`=1) is undefined with reason 3 when its register number `instr[19:16]` is not 0, 1, 8, 9 or 10.
- R5: A control move to register 8, 9 or 10 while `user_mode`=1 is undefined with reason 4. Registers 0 and 1 are legal in either mode.
- R6: An arithmetic op with `is_dbl`=1 is undefined with reason 5 when any register field is odd. The odd bits are `instr[22]` (destination), `instr[7]` (first operand) and `instr[5]` (second operand).
- R7: A legal multiple load/store (P=0, or W=1) is unpredictable with reason 6 in any of these cases: `xfer_cnt` is 0 or above 32; `start_reg + xfer_cnt` exceeds 32 for single precision; or it exceeds 16 for double precision. A single load/store (P=1,W=0) is never flagged.
- R8: A legal arithmetic op with `vec_len`≠0 and destination bank `instr[15:14]`≠0 is unpredictable with reason 7 when its register sequence repeats. The sequence has `vec_len+1` elements. Element i uses register `({instr[13:12],instr[22]} + i*step) mod 8`, where step is 1, doubled when `vec_stride2`=1 and doubled again when `is_dbl`=1.
- R9: Undefined reasons override unpredictable ones. `undef` and `unpred` are never both 1. A word with no rule hit reports reason 0 with both flags low.
- R10: While `rst` is high, all outputs are cleared on the next clock edge, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word present this cycle |
| instr | input | 32 | Instruction word |
| user_mode | input | 1 | 1 = unprivileged mode |
| is_dbl | input | 1 | Decoded precision, 1 = double |
| start_reg | input | REG_W (5) | First register of a multiple transfer |
| xfer_cnt | input | CNT_W (6) | Register count of a multiple transfer |
| vec_len | input | LEN_W (3) | Vector length minus one |
| vec_stride2 | input | 1 | 1 = vector stride of two |
| out_valid | output | 1 | Verdict present |
| undef | output | 1 | Word must bounce as undefined |
| unpred | output | 1 | Word has unpredictable result |
| reason | output | 3 | Rule that fired, 0 if none |

## Verification
The bench builds the block at its defaults: 32 single registers, a 6-bit count, 8-element vectors and 8-register banks. With the 6-bit count, values 33 and 63 can be applied, so the over-32 rule is reachable. With the 8-element length, the unit-stride single-precision case can run right up to the eight-element limit without wrapping. Starts at 7, 15, 23 and 31 combine with counts 0, 1, 32 and 33 in both precisions, so each bank edge is crossed.

// File: rtl/fpl_pkg.sv
package fpl_pkg;

  typedef enum logic [2:0] {
    RSN_NONE      = 3'd0,
    RSN_RESV_OP   = 3'd1,
    RSN_ADDR_MODE = 3'd2,
    RSN_CREG_NONE = 3'd3,
    RSN_CREG_PRIV = 3'd4,
    RSN_ODD_DREG  = 3'd5,
    RSN_XFER_SPAN = 3'd6,
    RSN_VEC_WRAP  = 3'd7
  } reason_e;

  localparam logic [2:0]  CLS_LDST   = 3'b110;
  localparam logic [2:0]  CLS_COPR   = 3'b111;
  localparam logic [3:0]  COND_NEVER = 4'hF;
  localparam logic [2:0]  CPNUM_HI   = 3'b101;
  localparam logic [3:0]  OP_EXT     = 4'd12;
  localparam logic [3:0]  OP_RESV_LO = 4'd13;
  localparam logic [3:0]  SUB_RESV_LO = 4'd9;
  // one bit per control register number: implemented / privileged-only
  localparam logic [15:0] CREG_IMPL  = 16'h0703;
  localparam logic [15:0] CREG_PRIV  = 16'h0700;

  typedef struct packed {
    logic resv_op;
    logic addr_mode;
    logic creg_none;
    logic creg_priv;
    logic odd_dreg;
    logic xfer_span;
    logic vec_wrap;
  } rule_hits_t;

endpackage

// File: rtl/fpl_ctrl_check.sv
module fpl_ctrl_check #(
  parameter logic [15:0] IMPL_MASK = 16'h0703,
  parameter logic [15:0] PRIV_MASK = 16'h0700
) (
  input  logic       is_move,
  input  logic       user_mode,
  input  logic [3:0] creg,
  output logic       creg_none,
  output logic       creg_priv
);
  logic impl_bit, priv_bit;

  always_comb begin
    impl_bit  = IMPL_MASK[creg];
    priv_bit  = PRIV_MASK[creg];
    creg_none = is_move & ~impl_bit;
    creg_priv = is_move & impl_bit & priv_bit & user_mode;
  end
endmodule

// File: rtl/fpl_xfer_check.sv
module fpl_xfer_check #(
  parameter int NUM_SREG = 32,
  parameter int REG_W    = 5,
  parameter int CNT_W    = 6
) (
  input  logic             is_ldst,
  input  logic             p_bit,
  input  logic             u_bit,
  input  logic             w_bit,
  input  logic             is_dbl,
  input  logic [REG_W-1:0] start_reg,
  input  logic [CNT_W-1:0] xfer_cnt,
  output logic             addr_bad,
  output logic             span_bad
);
  localparam int SUM_W = ((REG_W > CNT_W) ? REG_W : CNT_W) + 2;
  localparam logic [SUM_W-1:0] LIM_SGL = SUM_W'(NUM_SREG);
  localparam logic [SUM_W-1:0] LIM_DBL = SUM_W'(NUM_SREG / 2);
  localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'(NUM_SREG);

  logic [SUM_W-1:0] cnt_ext, end_reg, limit;
  logic             multi;

  always_comb begin
    cnt_ext  = SUM_W'(xfer_cnt);
    end_reg  = SUM_W'(start_reg) + cnt_ext;
    limit    = is_dbl ? LIM_DBL : LIM_SGL;
    addr_bad = is_ldst & ((~p_bit & ~u_bit) | (p_bit & u_bit & w_bit));
    multi    = is_ldst & ~addr_bad & (~p_bit | w_bit);
    span_bad = multi & ((cnt_ext == '0) | (cnt_ext > CNT_MAX) | (end_reg > limit));
  end
endmodule

// File: rtl/fpl_vec_wrap.sv
module fpl_vec_wrap #(
  parameter int MAX_ELEM = 8,
  parameter int BANK     = 8,
  localparam int LEN_W   = $clog2(MAX_ELEM),
  localparam int IDX_W   = $clog2(BANK)
) (
  input  logic             is_dbl,
  input  logic             stride2,
  input  logic [IDX_W-1:0] base,
  input  logic [LEN_W-1:0] len,
  output logic             wrap
);
  logic [2:0]       step;
  logic [IDX_W-1:0] idx [MAX_ELEM];
  logic [MAX_ELEM-1:0][MAX_ELEM-1:0] pair_hit;

  always_comb begin
    step = 3'd1;
    if (stride2) step = step << 1;
    if (is_dbl)  step = step << 1;
    for (int e = 0; e < MAX_ELEM; e++)
      idx[e] = IDX_W'(int'(base) + e * int'(step));
  end

  // element a collides with any earlier element b while a is inside the vector
  for (genvar a = 0; a < MAX_ELEM; a++) begin : g_row
    for (genvar b = 0; b < MAX_ELEM; b++) begin : g_col
      if (b < a) begin : g_cmp
        assign pair_hit[a][b] = ((LEN_W+1)'(a) <= {1'b0, len}) && (idx[a] == idx[b]);
      end else begin : g_off
        assign pair_hit[a][b] = 1'b0;
      end
    end
  end

  assign wrap = |pair_hit;
endmodule

// File: rtl/fpl_legality_top.sv
module fpl_legality_top
  import fpl_pkg::*;
#(
  parameter int NUM_SREG = 32,
  parameter int CNT_W    = 6,
  parameter int MAX_ELEM = 8,
  parameter int BANK     = 8,
  localparam int REG_W   = $clog2(NUM_SREG),
  localparam int LEN_W   = $clog2(MAX_ELEM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [31:0]      instr,
  input  logic             user_mode,
  input  logic             is_dbl,
  input  logic [REG_W-1:0] start_reg,
  input  logic [CNT_W-1:0] xfer_cnt,
  input  logic [LEN_W-1:0] vec_len,
  input  logic             vec_stride2,
  output logic             out_valid,
  output logic             undef,
  output logic             unpred,
  output logic [2:0]       reason
);
  localparam int IDX_W = $clog2(BANK);

  logic [2:0] cls;
  logic [3:0] opcode;
  logic       is_ldst, is_copr, is_move, is_arith, cp_ok, vec_on;
  logic       addr_bad, span_bad, creg_none, creg_priv, wrap_raw;
  rule_hits_t hits;
  reason_e    rsn_n;
  logic       undef_n, unpred_n;

  always_comb begin
    cls      = instr[27:25];
    opcode   = {instr[24], instr[21:20], instr[6]};
    is_ldst  = (cls == CLS_LDST);
    is_copr  = (cls == CLS_COPR);
    is_move  = is_copr & instr[4];
    is_arith = is_copr & ~instr[4];
    cp_ok    = (instr[11:9] == CPNUM_HI);
    vec_on   = is_arith & (vec_len != '0) & (instr[15:14] != 2'b00);
  end

  fpl_ctrl_check #(
    .IMPL_MASK (CREG_IMPL),
    .PRIV_MASK (CREG_PRIV)
  ) u_ctrl (
    .is_move   (is_move),
    .user_mode (user_mode),
    .creg      (instr[19:16]),
    .creg_none (creg_none),
    .creg_priv (creg_priv)
  );

  fpl_xfer_check #(
    .NUM_SREG (NUM_SREG),
    .REG_W    (REG_W),
    .CNT_W    (CNT_W)
  ) u_xfer (
    .is_ldst   (is_ldst),
    .p_bit     (instr[24]),
    .u_bit     (instr[23]),
    .w_bit     (instr[21]),
    .is_dbl    (is_dbl),
    .start_reg (start_reg),
    .xfer_cnt  (xfer_cnt),
    .addr_bad  (addr_bad),
    .span_bad  (span_bad)
  );

  fpl_vec_wrap #(
    .MAX_ELEM (MAX_ELEM),
    .BANK     (BANK)
  ) u_vec (
    .is_dbl  (is_dbl),
    .stride2 (vec_stride2),
    .base    (IDX_W'({instr[13:12], instr[22]})),
    .len     (vec_len),
    .wrap    (wrap_raw)
  );

  always_comb begin
    hits.resv_op   = (instr[31:28] == COND_NEVER) | ~(is_ldst | is_copr) | ~cp_ok |
                     (is_arith & ((opcode >= OP_RESV_LO) |
                                  ((opcode == OP_EXT) & (instr[3:0] >= SUB_RESV_LO))));
    hits.addr_mode = addr_bad;
    hits.creg_none = creg_none;
    hits.creg_priv = creg_priv;
    hits.odd_dreg  = is_arith & is_dbl & (instr[22] | instr[7] | instr[5]);
    hits.xfer_span = span_bad;
    hits.vec_wrap  = vec_on & wrap_raw;

    if      (hits.resv_op)   rsn_n = RSN_RESV_OP;
    else if (hits.addr_mode) rsn_n = RSN_ADDR_MODE;
    else if (hits.creg_none) rsn_n = RSN_CREG_NONE;
    else if (hits.creg_priv) rsn_n = RSN_CREG_PRIV;
    else if (hits.odd_dreg)  rsn_n = RSN_ODD_DREG;
    else if (hits.xfer_span) rsn_n = RSN_XFER_SPAN;
    else if (hits.vec_wrap)  rsn_n = RSN_VEC_WRAP;
    else                     rsn_n = RSN_NONE;

    undef_n  = hits.resv_op | hits.addr_mode | hits.creg_none | hits.creg_priv | hits.odd_dreg;
    unpred_n = ~undef_n & (hits.xfer_span | hits.vec_wrap);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      undef     <= 1'b0;
      unpred    <= 1'b0;
      reason    <= 3'd0;
    end else begin
      out_valid <= in_valid;
      undef     <= in_valid & undef_n;
      unpred    <= in_valid & unpred_n;
      reason    <= in_valid ? rsn_n : RSN_NONE;
    end
  end
endmodule

// File: rtl/fpl_legality_sva.sv
module fpl_legality_sva (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [31:0] instr,
  input logic        user_mode,
  input logic        is_dbl,
  input logic        out_valid,
  input logic        undef,
  input logic        unpred,
  input logic [2:0]  reason
);
  logic frame_ok, is_move, is_arith, op_plain;

  always_comb begin
    frame_ok = (instr[31:28] != 4'hF) && (instr[11:9] == 3'b101);
    is_move  = frame_ok && (instr[27:25] == 3'b111) && instr[4];
    is_arith = frame_ok && (instr[27:25] == 3'b111) && !instr[4];
    op_plain = ({instr[24], instr[21:20], instr[6]} < 4'd12);
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !undef && !unpred && reason == 3'd0));

  assert_addr_mode_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && frame_ok && instr[27:25] == 3'b110 && !instr[24] && !instr[23])
    |=> (undef && reason == 3'd2));

  assert_creg_unknown_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_move && instr[19:16] != 4'd0 && instr[19:16] != 4'd1 &&
     instr[19:16] != 4'd8 && instr[19:16] != 4'd9 && instr[19:16] != 4'd10)
    |=> (undef && reason == 3'd3));

  assert_creg_priv_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_move && user_mode && instr[19:16] >= 4'd8 && instr[19:16] <= 4'd10)
    |=> (undef && reason == 3'd4));

  assert_odd_dreg_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_arith && op_plain && is_dbl && instr[22])
    |=> (undef && reason == 3'd5));

  assert_flag_excl_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(undef && unpred));

  assert_unpred_code_R9: assert property (@(posedge clk) disable iff (rst)
    unpred |-> (reason == 3'd6 || reason == 3'd7));

  assert_undef_code_R9: assert property (@(posedge clk) disable iff (rst)
    undef |-> (reason != 3'd0 && reason < 3'd6));
endmodule

bind fpl_legality_top fpl_legality_sva u_sva (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .instr     (instr),
  .user_mode (user_mode),
  .is_dbl    (is_dbl),
  .out_valid (out_valid),
  .undef     (undef),
  .unpred    (unpred),
  .reason    (reason)
);

// File: tb/tb_fpl_legality_top.sv
`timescale 1ns/1ps
module tb_fpl_legality_top;
  localparam int REG_W = 5;
  localparam int CNT_W = 6;
  localparam int LEN_W = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic [31:0]      instr = '0;
  logic             user_mode = 1'b0;
  logic             is_dbl = 1'b0;
  logic [REG_W-1:0] start_reg = '0;
  logic [CNT_W-1:0] xfer_cnt = '0;
  logic [LEN_W-1:0] vec_len = '0;
  logic             vec_stride2 = 1'b0;
  logic             out_valid, undef, unpred;
  logic [2:0]       reason;

  int    checks = 0, failures = 0;
  bit    done = 1'b0;
  bit    pv = 1'b0, pu = 1'b0, pp = 1'b0;
  int    pr = 0;
  string ptag = "R10";
  int    seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  fpl_legality_top dut (
    .clk (clk), .rst (rst), .in_valid (in_valid), .instr (instr),
    .user_mode (user_mode), .is_dbl (is_dbl), .start_reg (start_reg),
    .xfer_cnt (xfer_cnt), .vec_len (vec_len), .vec_stride2 (vec_stride2),
    .out_valid (out_valid), .undef (undef), .unpred (unpred), .reason (reason)
  );

  // behavioural reference: rule order of R2..R8, first hit wins (R9)
  function automatic int ref_reason(logic [31:0] w, bit usr, bit dbl, int st, int cnt,
                                    int len, bit s2);
    int cls = int'(w[27:25]);
    if (w[31:28] == 4'hF || (cls != 6 && cls != 7) || (w[11:8] != 4'hA && w[11:8] != 4'hB))
      return 1;
    if (cls == 6) begin
      bit p = w[24], u = w[23], wb = w[21];
      if ((!p && !u) || (p && u && wb)) return 2;
      if (!p || wb) begin
        int lim = dbl ? 16 : 32;
        if (cnt == 0 || cnt > 32 || st + cnt > lim) return 6;
      end
      return 0;
    end
    if (w[4]) begin
      int cr = int'(w[19:16]);
      if (!(cr == 0 || cr == 1 || cr == 8 || cr == 9 || cr == 10)) return 3;
      if (usr && cr >= 8) return 4;
      return 0;
    end
    begin
      int op = int'({w[24], w[21:20], w[6]});
      if (op >= 13 || (op == 12 && w[3:0] >= 4'd9)) return 1;
      if (dbl && (w[22] || w[7] || w[5])) return 5;
      if (len != 0 && w[15:14] != 2'b00) begin
        bit seen [8];
        int step = (s2 ? 2 : 1) * (dbl ? 2 : 1);
        int base = int'({w[13:12], w[22]});
        foreach (seen[k]) seen[k] = 1'b0;
        for (int i = 0; i <= len; i++) begin
          int x = (base + i * step) % 8;
          if (seen[x]) return 7;
          seen[x] = 1'b1;
        end
      end
    end
    return 0;
  endfunction

  function automatic logic [31:0] mk_ls(bit p, bit u, bit wb);
    logic [31:0] w = '0;
    w[31:28] = 4'hE; w[27:25] = 3'b110; w[24] = p; w[23] = u; w[21] = wb; w[11:8] = 4'hA;
    return w;
  endfunction

  function automatic logic [31:0] mk_move(logic [3:0] cr);
    logic [31:0] w = '0;
    w[31:28] = 4'hE; w[27:25] = 3'b111; w[19:16] = cr; w[11:8] = 4'hA; w[4] = 1'b1;
    return w;
  endfunction

  function automatic logic [31:0] mk_arith(logic [3:0] op, logic [4:0] d, logic [4:0] n, logic [4:0] m);
    logic [31:0] w = '0;
    w[31:28] = 4'hE; w[27:25] = 3'b111; w[11:8] = 4'hB;
    w[24] = op[3]; w[21:20] = op[2:1]; w[6] = op[0];
    w[15:12] = d[4:1]; w[22] = d[0];
    w[19:16] = n[4:1]; w[7] = n[0];
    w[3:0] = m[4:1]; w[5] = m[0];
    return w;
  endfunction

  task automatic check_now();
    checks++;
    if (out_valid !== pv || undef !== pu || unpred !== pp || reason !== 3'(pr)) begin
      failures++;
      $display("FAIL %s: got v=%0b u=%0b p=%0b r=%0d expected v=%0b u=%0b p=%0b r=%0d",
               ptag, out_valid, undef, unpred, reason, pv, pu, pp, pr);
    end
  endtask

  task automatic issue(bit v, logic [31:0] w, bit usr, bit dbl, int st, int cnt, int len, bit s2);
    @(negedge clk);
    check_now();
    in_valid = v; instr = w; user_mode = usr; is_dbl = dbl;
    start_reg = REG_W'(st); xfer_cnt = CNT_W'(cnt); vec_len = LEN_W'(len); vec_stride2 = s2;
    pv = v;
    pr = v ? ref_reason(w, usr, dbl, st, cnt, len, s2) : 0;
    pu = (pr >= 1 && pr <= 5);
    pp = (pr >= 6);
    ptag = !v ? "R1" : (pr == 0) ? "R9" : $sformatf("R%0d", pr + 1);
  endtask

  task automatic idle();
    issue(1'b0, 32'h0, 1'b0, 1'b0, 0, 0, 0, 1'b0);
  endtask

  function automatic int nxt();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >>> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  initial begin
    // R10: outputs cleared during reset
    repeat (3) begin @(negedge clk); ptag = "R10"; check_now(); end
    @(negedge clk); rst = 1'b0;
    idle();
    idle();

    // R2: bad condition, foreign classes, wrong coprocessor number, reserved opcodes
    issue(1'b1, {4'hF, mk_move(4'd1)}[31:0] | 32'hF000_0000, 1'b0, 1'b0, 0, 0, 0, 1'b0);
    for (int c = 0; c < 6; c++)
      issue(1'b1, {4'hE, 3'(c), 25'h0000A00}, 1'b0, 1'b0, 0, 1, 0, 1'b0);
    for (int cp = 0; cp < 16; cp++) begin
      logic [31:0] w = mk_move(4'd0);
      w[11:8] = 4'(cp);
      issue(1'b1, w, 1'b0, 1'b0, 0, 0, 0, 1'b0);
    end
    for (int op = 0; op < 16; op++)
      issue(1'b1, mk_arith(4'(op), 5'd2, 5'd4, 5'd6), 1'b0, 1'b0, 0, 0, 0, 1'b0);
    for (int sub = 0; sub < 16; sub++)
      issue(1'b1, mk_arith(4'd12, 5'd0, 5'd0, {4'(sub), 1'b0}), 1'b0, 1'b0, 0, 0, 0, 1'b0);

    // R3: every addressing combination, a legal in-range transfer otherwise
    for (int pwu = 0; pwu < 8; pwu++)
      issue(1'b1, mk_ls(pwu[2], pwu[1], pwu[0]), 1'b0, 1'b0, 4, 4, 0, 1'b0);

    // R4, R5: all control register numbers in both modes
    for (int usr = 0; usr < 2; usr++)
      for (int cr = 0; cr < 16; cr++)
        issue(1'b1, mk_move(4'(cr)), usr[0], 1'b0, 0, 0, 0, 1'b0);

    // R6: odd destination / operand registers in double, same words in single
    for (int dbl = 0; dbl < 2; dbl++) begin
      issue(1'b1, mk_arith(4'd1, 5'd3, 5'd4, 5'd6), 1'b0, dbl[0], 0, 0, 0, 1'b0);
      issue(1'b1, mk_arith(4'd1, 5'd2, 5'd5, 5'd6), 1'b0, dbl[0], 0, 0, 0, 1'b0);
      issue(1'b1, mk_arith(4'd1, 5'd2, 5'd4, 5'd7), 1'b0, dbl[0], 0, 0, 0, 1'b0);
      issue(1'b1, mk_arith(4'd1, 5'd2, 5'd4, 5'd6), 1'b0, dbl[0], 0, 0, 0, 1'b0);
    end

    // R7: counts 0,1,32,33 and others against starts near each bank top
    for (int dbl = 0; dbl < 2; dbl++)
      for (int si = 0; si < 9; si++)
        for (int ci = 0; ci < 8; ci++) begin
          int starts [9] = '{0, 7, 8, 15, 16, 23, 24, 30, 31};
          int cnts [8]   = '{0, 1, 2, 16, 17, 32, 33, 63};
          issue(1'b1, mk_ls(1'b0, 1'b1, 1'b1), 1'b0, dbl[0], starts[si], cnts[ci], 0, 1'b0);
          issue(1'b1, mk_ls(1'b1, 1'b0, 1'b0), 1'b0, dbl[0], starts[si], cnts[ci], 0, 1'b0);
        end

    // R8: every length, stride and precision, each start within a nonzero bank
    for (int dbl = 0; dbl < 2; dbl++)
      for (int s2 = 0; s2 < 2; s2++)
        for (int len = 0; len < 8; len++)
          for (int b = 0; b < 8; b += (dbl ? 2 : 1))
            issue(1'b1, mk_arith(4'd2, 5'(8 + b), 5'd0, 5'd0), 1'b0, dbl[0], 0, 0, len, s2[0]);
    // R8: bank 0 destination stays scalar even with a wrapping length
    issue(1'b1, mk_arith(4'd2, 5'd2, 5'd0, 5'd0), 1'b0, 1'b1, 0, 0, 7, 1'b1);

    // R9: undefined masks unpredictable
    issue(1'b1, mk_arith(4'd2, 5'd9, 5'd0, 5'd0), 1'b0, 1'b1, 0, 0, 7, 1'b1);
    issue(1'b1, mk_ls(1'b0, 1'b0, 1'b1), 1'b0, 1'b1, 31, 0, 0, 1'b0);

    // R1: gaps between valids
    issue(1'b1, mk_move(4'd1), 1'b1, 1'b0, 0, 0, 0, 1'b0);
    idle();
    issue(1'b1, mk_move(4'd3), 1'b1, 1'b0, 0, 0, 0, 1'b0);
    idle();

    // R10: reset taking priority over a valid word
    issue(1'b1, mk_move(4'd5), 1'b0, 1'b0, 0, 0, 0, 1'b0);
    @(negedge clk);
    check_now();
    rst = 1'b1; in_valid = 1'b1; instr = mk_move(4'd6);
    pv = 0; pu = 0; pp = 0; pr = 0; ptag = "R10";
    @(negedge clk);
    check_now();
    rst = 1'b0; in_valid = 1'b0; ptag = "R1";

    // mixed pseudo-random words, mostly with a legal frame
    for (int k = 0; k < 400; k++) begin
      logic [31:0] w = 32'(nxt());
      int aux = nxt();
      if (aux[0]) begin w[31:28] = 4'hE; w[11:9] = 3'b101; w[27] = 1'b1; w[26] = 1'b1; end
      issue(aux[1], w, aux[2], aux[3], (aux >>> 4) & 31, (aux >>> 9) & 63,
            (aux >>> 15) & 7, aux[18]);
    end
    idle();
    idle();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule